// File: doc/BRIEF.md
# Synchronous Burst Static RAM with Byte-Lane Writes

This block is a clocked static RAM intended to hold cache data lines. Address, write data and all control strobes except the output enable are captured on the rising clock edge. An access begins when either of two active-low address strobes is sampled low: one strobe belongs to the processor and the other to the cache controller. That edge loads the address into an internal burst register and clears a 2-bit beat counter. Each later edge with the advance input low then reaches the next word of the aligned four-word group, in interleaved order.

Each word has two 9-bit lanes, and each lane has its own write enable, so either half of a word can be written alone. The processor strobe always makes its own edge a read. Read data is registered and appears one clock after the address is captured. An output-valid flag is gated without a clock by the output enable and is low during write cycles. Width, lane size and depth are parameters. The default depth is kept small for simulation, and the full 65,536-word array uses `ADDR_W = 16`.

Top module: `sync_burst_ram`

## Requirements
- R1: A read access captures the address at a rising edge. The addressed word is on `dout` with `dout_vld` high after that edge, provided `oe_n` is low.
- R2: An edge with `proc_stb_n` low or `ctrl_stb_n` low starts a burst. It loads the address, resets the beat counter to 0 and samples `ce_n`: 0 selects the device and 1 deselects it.
- R3: Beat k of a burst, counting from 0, accesses the word whose two low address bits are the starting low bits XOR (k mod 4). The upper address bits keep their start value, so the burst wraps inside the aligned four-word group.
- R4: The beat counter steps only on edges with `adv_n` low and no strobe. On an edge with no strobe and `adv_n` high, `dout` and `dout_vld` keep their values.
- R5: `wen_lo_n` low writes bits 8..0 and `wen_hi_n` low writes bits 17..9. A lane whose enable is high keeps its stored value.
- R6: On an edge with `proc_stb_n` low, the access is a read and nothing is written, even if a write enable is low.
- R7: An access is a write when `proc_stb_n` is high and at least one write enable is low. The write completes at that edge, and a later read returns the new data.
- R8: `oe_n` acts without a clock. With `oe_n` high, `dout_vld` is 0 and `dout` is all zeros. When `oe_n` returns low, the held read data shows again.
- R9: After a write access, `dout_vld` is 0 whatever `oe_n` is.
- R10: While deselected, advance edges change nothing. They write nothing, `dout_vld` stays 0, and the counter does not move until a strobe edge with `ce_n` low.
- R11: After reset the device is deselected, `dout_vld` is 0 and `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Word address, used on strobe edges |
| din | input | DATA_W | Write data |
| proc_stb_n | input | 1 | Processor address strobe, active low, forces a read |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wen_lo_n | input | 1 | Low-lane write enable (bits 8..0), active low |
| wen_hi_n | input | 1 | High-lane write enable (bits 17..9), active low |
| ce_n | input | 1 | Chip enable, sampled on strobe edges, active low |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| dout | output | DATA_W | Read data, zero when not valid |
| dout_vld | output | 1 | Read data valid |

## Verification
Inputs change at the falling edge, so each access is captured at the next rising edge. The bench samples `dout` and `dout_vld` at the falling edge that follows. One register stands between the captured address and the data, so every access result is due exactly one edge after its stimulus. Writes are checked by a read burst issued later, and the bench's data model is updated at the edge that performs the write. The output-enable checks are the exception: the bench changes `oe_n` between edges and samples one time unit later, with no clock edge in between.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
   localparam int BEATS = 4;

   // Interleaved beat order: low address bits of a beat.
   function automatic logic [1:0] beat_low(input logic [1:0] start_lo,
                                           input logic [1:0] beat);
      return start_lo ^ beat;
   endfunction
endpackage

// File: rtl/sbr_seq.sv
module sbr_seq #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              proc_stb_n,
   input  logic              ctrl_stb_n,
   input  logic              adv_n,
   input  logic              ce_n,
   input  logic              wen_lo_n,
   input  logic              wen_hi_n,
   output logic              strobe,
   output logic              acc,
   output logic [ADDR_W-1:0] acc_addr,
   output logic              we_lo,
   output logic              we_hi,
   output logic              rd
);
   if (ADDR_W < 3) begin : g_bad_aw
      $error("sbr_seq: ADDR_W must be at least 3");
   end

   logic [ADDR_W-1:0] base_q;
   logic [1:0]        cnt_q, cnt_nx;
   logic              sel_q, step, wr_ok;

   assign strobe = !proc_stb_n || !ctrl_stb_n;
   assign step   = !strobe && sel_q && !adv_n;
   assign cnt_nx = cnt_q + 2'd1;

   always_comb begin
      if (strobe) acc_addr = addr;
      else        acc_addr = {base_q[ADDR_W-1:2], sbr_pkg::beat_low(base_q[1:0], cnt_nx)};
   end

   assign acc   = strobe ? !ce_n : step;
   assign wr_ok = acc && proc_stb_n;
   assign we_lo = wr_ok && !wen_lo_n;
   assign we_hi = wr_ok && !wen_hi_n;
   assign rd    = acc && !(we_lo || we_hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= 1'b0;
         base_q <= '0;
         cnt_q  <= 2'd0;
      end else if (strobe) begin
         sel_q  <= !ce_n;
         base_q <= addr;
         cnt_q  <= 2'd0;
      end else if (step) begin
         cnt_q  <= cnt_nx;
      end
   end

   // R10
   desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_q && !strobe) |-> !acc);
   // R4
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q && !strobe && !adv_n) |=> (cnt_q == $past(cnt_q) + 2'd1));
   // R4
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && adv_n) |=> $stable(cnt_q));
   // R6
   proc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !proc_stb_n |-> !(we_lo || we_hi));
endmodule

// File: rtl/sbr_array.sv
module sbr_array #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 18,
   parameter int LANE_W = 9
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [DATA_W-1:0]         wdata,
   input  logic [DATA_W/LANE_W-1:0]  we,
   input  logic                      rd,
   output logic [DATA_W-1:0]         rdata
);
   localparam int LANES = DATA_W / LANE_W;
   localparam int DEPTH = 1 << ADDR_W;

   if (LANES * LANE_W != DATA_W) begin : g_bad_lane
      $error("sbr_array: DATA_W must be a multiple of LANE_W");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] q;

      always_ff @(posedge clk) begin
         if (we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  q <= '0;
         else if (rd) q <= mem[addr];
      end

      assign rdata[g*LANE_W +: LANE_W] = q;
   end
endmodule

// File: rtl/sync_burst_ram.sv
module sync_burst_ram #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 18,
   parameter int LANE_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              proc_stb_n,
   input  logic              ctrl_stb_n,
   input  logic              adv_n,
   input  logic              wen_lo_n,
   input  logic              wen_hi_n,
   input  logic              ce_n,
   input  logic              oe_n,
   output logic [DATA_W-1:0] dout,
   output logic              dout_vld
);
   localparam int LANES = DATA_W / LANE_W;

   if (LANES != 2) begin : g_bad_split
      $error("sync_burst_ram: exactly two write lanes are supported");
   end

   logic              strobe, acc, we_lo, we_hi, rd, rd_q;
   logic [ADDR_W-1:0] acc_addr;
   logic [DATA_W-1:0] rdata;
   logic [LANES-1:0]  lane_we;

   sbr_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .addr(addr),
      .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n),
      .ce_n(ce_n), .wen_lo_n(wen_lo_n), .wen_hi_n(wen_hi_n),
      .strobe(strobe), .acc(acc), .acc_addr(acc_addr),
      .we_lo(we_lo), .we_hi(we_hi), .rd(rd)
   );

   assign lane_we = {we_hi, we_lo};

   sbr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_array (
      .clk(clk), .rst_n(rst_n), .addr(acc_addr), .wdata(din),
      .we(lane_we), .rd(rd), .rdata(rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              rd_q <= 1'b0;
      else if (acc || strobe)  rd_q <= rd;
   end

   assign dout_vld = rd_q && !oe_n;
   assign dout     = dout_vld ? rdata : '0;

   // R8
   oe_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (!dout_vld && dout == '0));
   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && adv_n) |=> ($stable(rdata) && $stable(rd_q)));
   // R9
   write_novld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_lo || we_hi) |=> !dout_vld);
endmodule

// File: tb/sync_burst_ram_test.sv
`timescale 1ns/1ps
module sync_burst_ram_test;
   localparam int AW    = 10;
   localparam int DW    = 18;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic          proc_stb_n = 1'b1, ctrl_stb_n = 1'b1, adv_n = 1'b1;
   logic          wen_lo_n = 1'b1, wen_hi_n = 1'b1, ce_n = 1'b0, oe_n = 1'b0;
   logic [DW-1:0] dout;
   logic          dout_vld;

   logic [DW-1:0] mdl [DEPTH];
   int            n_chk = 0, n_fail = 0;
   logic [DW-1:0] held;

   always #4 clk = ~clk;

   sync_burst_ram #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(9)) uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
      .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n),
      .wen_lo_n(wen_lo_n), .wen_hi_n(wen_hi_n), .ce_n(ce_n), .oe_n(oe_n),
      .dout(dout), .dout_vld(dout_vld)
   );

   function automatic logic [DW-1:0] pat(input int a);
      return DW'((a * 2731 + 341) ^ (a << 9));
   endfunction

   function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] a, input int k);
      return {a[AW-1:2], a[1:0] ^ 2'(k)};
   endfunction

   task automatic chk(input string tag, input logic [DW-1:0] exp_d, input logic exp_v);
      n_chk++;
      if (dout !== exp_d || dout_vld !== exp_v) begin
         n_fail++;
         $display("FAIL %s: dout=%h vld=%b expected dout=%h vld=%b", tag, dout, dout_vld, exp_d, exp_v);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      proc_stb_n = 1'b1; ctrl_stb_n = 1'b1; adv_n = 1'b1;
      wen_lo_n = 1'b1; wen_hi_n = 1'b1; ce_n = 1'b0;
   endtask

   task automatic wr_word(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic lo, input logic hi);
      addr = a; din = d; ctrl_stb_n = 1'b0; wen_lo_n = !lo; wen_hi_n = !hi;
      tick();
      if (lo) mdl[a][8:0]  = d[8:0];
      if (hi) mdl[a][17:9] = d[17:9];
      idle();
   endtask

   // Proc-strobe read at a, then nb-1 advances; each beat checked (R1, R3).
   task automatic rd_burst(input logic [AW-1:0] a, input int nb, input string tag);
      addr = a; proc_stb_n = 1'b0;
      tick();
      chk(tag, mdl[a], 1'b1);
      proc_stb_n = 1'b1;
      for (int k = 1; k < nb; k++) begin
         adv_n = 1'b0;
         tick();
         chk(tag, mdl[beat_addr(a, k)], 1'b1);
      end
      idle();
   endtask

   initial begin
      #(8 * 150000);
      n_fail++; n_chk++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      // R11: reset state
      chk("R11 reset", '0, 1'b0);
      rst_n = 1'b1;
      tick();
      chk("R11 after release", '0, 1'b0);
      // R10: advance while never selected after reset does nothing
      adv_n = 1'b0; wen_lo_n = 1'b0; tick(); idle();
      chk("R10 advance after reset", '0, 1'b0);

      // R7: fill every word through the controller strobe
      for (int a = 0; a < DEPTH; a++) begin
         wr_word(AW'(a), pat(a), 1'b1, 1'b1);
         // R9: write leaves output invalid even with oe_n low
         if (a < 4) chk("R9 write no valid", '0, 1'b0);
      end

      // R1 R3: every start offset of every group, full burst
      for (int b = 0; b < DEPTH; b += 4)
         for (int s = 0; s < 4; s++)
            rd_burst(AW'(b + s), 4, "R3 interleave sweep");

      // R3: a fifth advance wraps to the starting word
      rd_burst(AW'(13), 5, "R3 wrap");

      // R4: idle edges hold the output
      rd_burst(AW'(80), 1, "R4 start");
      held = mdl[80];
      for (int k = 0; k < 3; k++) begin
         tick();
         chk("R4 hold", held, 1'b1);
      end
      adv_n = 1'b0; tick(); idle();
      chk("R4 step after hold", mdl[81], 1'b1);

      // R8: asynchronous output enable
      oe_n = 1'b1; #1;
      chk("R8 oe high", '0, 1'b0);
      oe_n = 1'b0; #1;
      chk("R8 oe low again", mdl[81], 1'b1);
      // R9: write with oe_n low gives no valid data
      wr_word(AW'(90), 18'h2A5A5, 1'b1, 1'b1);
      chk("R9 write oe low", '0, 1'b0);
      rd_burst(AW'(90), 1, "R7 readback");

      // R5: lanes one at a time
      wr_word(AW'(32), 18'h3FFFF, 1'b1, 1'b0);
      rd_burst(AW'(32), 1, "R5 low lane only");
      wr_word(AW'(33), 18'h00000, 1'b0, 1'b1);
      rd_burst(AW'(33), 1, "R5 high lane only");

      // R7 R3: write burst through advances, start offset 1
      addr = AW'(261); din = 18'h11111; ctrl_stb_n = 1'b0; wen_lo_n = 1'b0; wen_hi_n = 1'b0;
      tick();
      mdl[261] = 18'h11111;
      ctrl_stb_n = 1'b1;
      for (int k = 1; k < 4; k++) begin
         din = DW'(18'h11111 * (k + 1)); adv_n = 1'b0;
         tick();
         mdl[beat_addr(AW'(261), k)] = DW'(18'h11111 * (k + 1));
         chk("R9 burst write", '0, 1'b0);
      end
      idle();
      rd_burst(AW'(260), 4, "R7 burst write readback");

      // R6: processor strobe with write enables low is a read
      addr = AW'(48); din = 18'h00001; proc_stb_n = 1'b0; wen_lo_n = 1'b0; wen_hi_n = 1'b0;
      tick(); idle();
      chk("R6 forced read", mdl[48], 1'b1);
      rd_burst(AW'(48), 1, "R6 unchanged");

      // R10: deselect at controller strobe, then advances with writes
      addr = AW'(64); din = 18'h0F0F0; ctrl_stb_n = 1'b0; ce_n = 1'b1; wen_lo_n = 1'b0;
      tick();
      chk("R2 R10 deselect", '0, 1'b0);
      ctrl_stb_n = 1'b1; ce_n = 1'b0;
      for (int k = 0; k < 3; k++) begin
         adv_n = 1'b0; wen_hi_n = 1'b0;
         tick();
         chk("R10 advance ignored", '0, 1'b0);
      end
      idle();
      rd_burst(AW'(64), 4, "R10 nothing written");
      // R2: processor strobe with ce_n high also deselects
      addr = AW'(70); proc_stb_n = 1'b0; ce_n = 1'b1;
      tick(); idle();
      chk("R2 proc deselect", '0, 1'b0);
      // R2: controller strobe read restarts at beat 0
      addr = AW'(71); ctrl_stb_n = 1'b0;
      tick(); idle();
      chk("R2 ctrl read", mdl[71], 1'b1);
      adv_n = 1'b0; tick(); idle();
      chk("R2 R3 ctrl advance", mdl[70], 1'b1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule